// File: doc/BRIEF.md
# Packet Buffer with Serial Bit Shifter

This block stores packet bytes for a radio packet engine. It holds 64 bytes of 8 bits each and connects them to a single-bit serial stream through an 8-bit shift register. A host side, framed by an active-low chip select, pushes bytes in and pops them out one whole byte at a time. A mode input sets the direction. In transmit mode the shifter pulls bytes from the buffer and presents them bit by bit, most significant bit first. In receive mode it gathers incoming bits and stores each finished byte.

A programmable divider sets the bit rate. It produces a one-cycle enable, and the shifter advances one bit on each enable. Five status outputs report the buffer and the shifter: empty, full, overrun, a level above a host-set threshold, and the end of a transmitted packet. The empty output is held steady while the chip select is low, so a read the host has already started always completes. Writing one to the overrun clear input clears the flag and also discards everything stored.

Top module: `pkt_fifo_serdes`

## Requirements
- R1: After a synchronous active-low reset: `fifo_empty`=1, `fifo_full`=0, `fifo_level`=0, `fifo_ovr`=0, `pkt_sent`=0, `tx_data`=0 and `host_rd_data`=0.
- R2: Host bytes come out in the order they were written. A pop is a cycle with `cs_n`=0 and `host_rd_en`=1 while the buffer holds data. The popped byte appears on `host_rd_data` one clock later.
- R3: `fifo_full` is 1 exactly when 64 bytes are stored. `fifo_empty` is 1 exactly when no byte is stored, as seen while `cs_n` stays high.
- R4: `fifo_level` is 1 exactly when the stored count is strictly greater than the 6-bit `fifo_thresh`.
- R5: A write while 64 bytes are stored sets `fifo_ovr` to 1. The new byte is dropped, and the stored bytes and their order are unchanged.
- R6: `ovr_clr`=1 with `cs_n`=0 clears `fifo_ovr` and empties the buffer in the same clock.
- R7: `fifo_empty` takes a new value only on a clock whose previous cycle had `cs_n`=1. Once `cs_n` has been low for a cycle, the flag holds until `cs_n` rises again.
- R8: `mode` is coded as 0 standby, 1 transmit and 2 receive; code 3 behaves as standby. Host writes are ignored when `cs_n`=1 or when `mode`=2. Host reads are ignored when `mode`=1.
- R9: In transmit or receive mode, `bit_en` pulses for one cycle every `bit_div`+1 clocks. In standby it stays 0.
- R10: In transmit mode each `bit_en` pulse moves the shifter by one bit. When the shifter needs a byte and one is stored, it loads that byte and shows bit 7 on `tx_data`. Each following pulse shows the next lower bit.
- R11: `pkt_sent` rises on the pulse after the last bit of a byte if no further byte is stored, and `tx_data` then returns to 0. `pkt_sent` clears when a new byte is loaded or when the mode changes.
- R12: In receive mode `rx_in` is sampled on each `bit_en` pulse, most significant bit first. Every eighth bit stores the assembled byte, and a byte that arrives while the buffer is full sets `fifo_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 standby, 1 transmit, 2 receive |
| cs_n | input | 1 | Active-low host chip select |
| host_wr_en | input | 1 | Host byte write strobe |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host byte read strobe |
| host_rd_data | output | 8 | Last byte popped by the host |
| ovr_clr | input | 1 | Write-one clear of overrun, also flushes |
| fifo_thresh | input | 6 | Level threshold |
| bit_div | input | 8 | Bit period minus one, in clocks |
| rx_in | input | 1 | Serial receive bit |
| tx_data | output | 1 | Serial transmit bit |
| bit_en | output | 1 | Bit-rate enable pulse |
| fifo_empty | output | 1 | Buffer empty, chip-select framed |
| fifo_full | output | 1 | Buffer full |
| fifo_level | output | 1 | Stored count above threshold |
| fifo_ovr | output | 1 | Overrun flag |
| pkt_sent | output | 1 | Transmit packet finished |

## Verification
The bench builds the block with its default parameters: a depth of 64, 8-bit bytes and an 8-bit divider. At the full depth it can reach the real full and overrun boundaries after 64 host writes, and the threshold extremes 0 and 63 can be tested against counts of 63 and 64. The divider is driven at small values during the serial tests, so multi-byte transmit and receive runs with `pkt_sent` finish in a few hundred clocks. It is set to its largest value when the bench needs receive mode to stay quiet while it checks that host writes are dropped.

// File: rtl/pkt_fifo_pkg.sv
// Package: shared mode encoding for the packet buffer and shifter.
// Assumes a 2-bit mode input; code 3 is treated as standby.
package pkt_fifo_pkg;
    typedef enum logic [1:0] {
        MODE_STBY = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2,
        MODE_RSVD = 2'd3
    } op_mode_e;
endpackage

// File: rtl/pkt_buf.sv
// Module: pkt_buf
// Circular byte store with read/write pointers and an occupancy count.
// Assumes at most one push source and one pop source per cycle.
// A push while full is dropped and sets the overrun flag.
// A flush clears the pointers, the count and the overrun flag, and it
// overrides any push or pop in the same cycle.
module pkt_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovr
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          wr_ok, rd_ok;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign wr_ok = push & ~full & ~flush;
    assign rd_ok = pop & ~empty & ~flush;
    assign head  = mem[rptr];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wptr] <= push_data;
        end
    end

    // Advance the pointers and count, and track overrun.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (wr_ok) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (rd_ok) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            count <= count + CW'(wr_ok) - CW'(rd_ok);
            if (push && full) begin
                ovr <= 1'b1;
            end
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)) else $error("count above depth"); // R3
    AST_OVR_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !flush) |=> ovr) else $error("overrun not set"); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full) else $error("full push changed count"); // R5
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !ovr)) else $error("flush incomplete"); // R6
endmodule

// File: rtl/bit_rate_gen.sv
// Module: bit_rate_gen
// Programmable divider that makes a one-cycle bit enable every div+1 clocks.
// Assumes en is high only while a serial mode is active. The counter
// restarts whenever en is low.
module bit_rate_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count clocks and emit the enable pulse at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || !$stable(div))) else $error("tick too wide"); // R9
    AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick) else $error("tick in standby"); // R9
endmodule

// File: rtl/serial_shifter.sv
// Module: serial_shifter
// Shift register between the byte store and the serial bit stream.
// In transmit mode it pops bytes and shifts them out MSB first, and it
// flags the end of a packet when the store runs dry. In receive mode it
// assembles 8 bits MSB first and requests a push per byte.
// Assumes head is valid whenever buf_empty is low. Any mode change resets
// the shifter state.
module serial_shifter
    import pkt_fifo_pkg::*;
#(
    parameter int DW  = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          tick,
    input  logic          buf_empty,
    input  logic [DW-1:0] head,
    input  logic          rx_in,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_byte,
    output logic          tx_data,
    output logic          pkt_sent
);
    logic [DW-1:0] sr;
    logic [BW-1:0] bcnt;
    logic          active;
    logic [1:0]    mode_q;
    logic          is_tx, is_rx, mode_chg, last_bit, need_byte;

    assign is_tx     = (mode == MODE_TX);
    assign is_rx     = (mode == MODE_RX);
    assign mode_chg  = (mode != mode_q);
    assign last_bit  = (bcnt == BW'(DW - 1));
    assign need_byte = ~active | last_bit;
    assign tx_pop    = tick & is_tx & ~mode_chg & need_byte & ~buf_empty;
    assign rx_push   = tick & is_rx & ~mode_chg & last_bit;
    assign rx_byte   = {sr[DW-2:0], rx_in};
    assign tx_data   = active & is_tx & sr[DW-1];

    // Remember the mode of the previous cycle to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STBY;
        end else begin
            mode_q <= mode;
        end
    end

    // Shift, load, assemble and flag end of packet on each bit enable.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg || !(is_tx || is_rx)) begin
            sr       <= '0;
            bcnt     <= '0;
            active   <= 1'b0;
            pkt_sent <= 1'b0;
        end else if (tick) begin
            if (is_tx) begin
                if (tx_pop) begin
                    sr       <= head;
                    bcnt     <= '0;
                    active   <= 1'b1;
                    pkt_sent <= 1'b0;
                end else if (need_byte) begin
                    if (active) begin
                        pkt_sent <= 1'b1;
                    end
                    sr     <= '0;
                    bcnt   <= '0;
                    active <= 1'b0;
                end else begin
                    sr   <= {sr[DW-2:0], 1'b0};
                    bcnt <= bcnt + 1'b1;
                end
            end else begin
                sr   <= rx_byte;
                bcnt <= last_bit ? '0 : bcnt + 1'b1;
            end
        end
    end

    AST_SENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_sent |-> !active) else $error("sent while shifting"); // R11
    AST_SENT_CLEARS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !pkt_sent) else $error("sent held over load"); // R11
endmodule

// File: rtl/pkt_fifo_serdes.sv
// Module: pkt_fifo_serdes (top)
// Packet byte store with a host port framed by an active-low chip select,
// a bit-rate divider and a serial shifter, plus the status flags.
// Assumes the host changes cs_n and its strobes synchronously to clk.
// Host writes are accepted outside receive mode, host reads outside
// transmit mode. The empty flag updates only after a cycle with cs_n high.
module pkt_fifo_serdes
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int DIV_W = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             cs_n,
    input  logic             host_wr_en,
    input  logic [DW-1:0]    host_wr_data,
    input  logic             host_rd_en,
    output logic [DW-1:0]    host_rd_data,
    input  logic             ovr_clr,
    input  logic [TW-1:0]    fifo_thresh,
    input  logic [DIV_W-1:0] bit_div,
    input  logic             rx_in,
    output logic             tx_data,
    output logic             bit_en,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             fifo_level,
    output logic             fifo_ovr,
    output logic             pkt_sent
);
    logic          host_push, host_pop, flush;
    logic          tx_pop, rx_push, push, pop;
    logic [DW-1:0] rx_byte, push_data, head;
    logic [CW-1:0] count;
    logic          buf_empty, cs_q, serial_on;

    assign host_push = ~cs_n & host_wr_en & (mode != MODE_RX);
    assign host_pop  = ~cs_n & host_rd_en & (mode != MODE_TX);
    assign flush     = ~cs_n & ovr_clr;
    assign push      = host_push | rx_push;
    assign push_data = rx_push ? rx_byte : host_wr_data;
    assign pop       = host_pop | tx_pop;
    assign serial_on = (mode == MODE_TX) | (mode == MODE_RX);
    assign fifo_level = (count > CW'(fifo_thresh));

    pkt_buf #(.DEPTH(DEPTH), .DW(DW)) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .full      (fifo_full),
        .empty     (buf_empty),
        .ovr       (fifo_ovr)
    );

    bit_rate_gen #(.DIV_W(DIV_W)) i_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (serial_on),
        .div   (bit_div),
        .tick  (bit_en)
    );

    serial_shifter #(.DW(DW)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .tick      (bit_en),
        .buf_empty (buf_empty),
        .head      (head),
        .rx_in     (rx_in),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_byte   (rx_byte),
        .tx_data   (tx_data),
        .pkt_sent  (pkt_sent)
    );

    // Capture the byte the host pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rd_data <= '0;
        end else if (host_pop && !buf_empty && !flush) begin
            host_rd_data <= head;
        end
    end

    // Framed empty flag: refresh only after a cycle with chip select high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q       <= 1'b1;
            fifo_empty <= 1'b1;
        end else begin
            cs_q <= cs_n;
            if (cs_q) begin
                fifo_empty <= buf_empty;
            end
        end
    end

    AST_EMPTY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |=> $stable(fifo_empty)) else $error("empty moved under cs"); // R7
    AST_RX_NO_HOST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RX && !rx_push) |=> (count <= $past(count))) else $error("host write in rx"); // R8
endmodule

// File: tb/test_pkt_fifo_serdes.sv
`timescale 1ns/1ps
module test_pkt_fifo_serdes;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       cs_n = 1'b1;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic       host_rd_en = 1'b0;
    logic [7:0] host_rd_data;
    logic       ovr_clr = 1'b0;
    logic [5:0] fifo_thresh = '0;
    logic [7:0] bit_div = 8'd3;
    logic       rx_in = 1'b0;
    logic       tx_data, bit_en, fifo_empty, fifo_full, fifo_level, fifo_ovr, pkt_sent;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    pkt_fifo_serdes i_pkt_fifo_serdes (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .ovr_clr(ovr_clr), .fifo_thresh(fifo_thresh), .bit_div(bit_div),
        .rx_in(rx_in), .tx_data(tx_data), .bit_en(bit_en),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_level(fifo_level),
        .fifo_ovr(fifo_ovr), .pkt_sent(pkt_sent)
    );

    // Fields: [15:9] bytes to fill, [8:3] threshold, [2] level, [1] full, [0] empty
    localparam logic [15:0] VEC [8] = '{
        {7'd0,  6'd0,  3'b001},
        {7'd1,  6'd0,  3'b100},
        {7'd5,  6'd5,  3'b000},
        {7'd6,  6'd5,  3'b100},
        {7'd63, 6'd62, 3'b100},
        {7'd64, 6'd63, 3'b110},
        {7'd64, 6'd0,  3'b110},
        {7'd32, 6'd63, 3'b000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        cs_n = 1'b0; host_wr_en = 1'b1; host_wr_data = b;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        cs_n = 1'b0; host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        b = host_rd_data;
    endtask

    task automatic do_flush();
        cs_n = 1'b0; ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
    endtask

    task automatic cs_release();
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_tick();
        while (bit_en !== 1'b1) @(negedge clk);
    endtask

    initial begin
        logic [7:0] b;
        int bad;
        int cyc;
        logic [7:0] txb [2];
        logic [7:0] rxb [2];

        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 empty", fifo_empty, 1);
        chk("R1 full", fifo_full, 0);
        chk("R1 level", fifo_level, 0);
        chk("R1 ovr", fifo_ovr, 0);
        chk("R1 sent", pkt_sent, 0);
        chk("R1 tx_data", tx_data, 0);
        chk("R1 rd_data", host_rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4 vector table in standby
        for (int v = 0; v < 8; v++) begin
            do_flush();
            for (int i = 0; i < int'(VEC[v][15:9]); i++) wr_byte(8'(i));
            fifo_thresh = VEC[v][8:3];
            cs_release();
            chk("R4 level", fifo_level, VEC[v][2]);
            chk("R3 full", fifo_full, VEC[v][1]);
            chk("R3 empty", fifo_empty, VEC[v][0]);
        end

        // R2 ordering
        do_flush();
        for (int i = 0; i < 5; i++) wr_byte(8'hA0 + 8'(i * 3));
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            rd_byte(b);
            if (b !== 8'hA0 + 8'(i * 3)) bad++;
        end
        chk("R2 order mismatches", bad, 0);
        cs_release();
        chk("R2 drained empty", fifo_empty, 1);

        // R5 overrun drops byte
        do_flush();
        for (int i = 0; i < 64; i++) wr_byte(8'(i + 7));
        chk("R5 ovr before", fifo_ovr, 0);
        wr_byte(8'hEE);
        chk("R5 ovr set", fifo_ovr, 1);
        chk("R5 still full", fifo_full, 1);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            rd_byte(b);
            if (b !== 8'(i + 7)) bad++;
        end
        chk("R5 stored bytes intact", bad, 0);
        cs_release();
        chk("R5 empty after drain", fifo_empty, 1);
        chk("R5 ovr sticky", fifo_ovr, 1);

        // R6 clear flushes
        for (int i = 0; i < 64; i++) wr_byte(8'h11);
        fifo_thresh = 6'd0;
        do_flush();
        chk("R6 ovr cleared", fifo_ovr, 0);
        chk("R6 full cleared", fifo_full, 0);
        chk("R6 level cleared", fifo_level, 0);
        cs_release();
        chk("R6 empty", fifo_empty, 1);

        // R7 empty frozen under chip select
        wr_byte(8'h5A);
        cs_release();
        chk("R7 not empty", fifo_empty, 0);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        rd_byte(b);
        chk("R7 read data", b, 8'h5A);
        repeat (3) @(negedge clk);
        chk("R7 held under cs", fifo_empty, 0);
        cs_release();
        chk("R7 updated after cs", fifo_empty, 1);

        // R8 writes with cs high ignored
        cs_n = 1'b1; host_wr_en = 1'b1; host_wr_data = 8'h33;
        @(negedge clk);
        host_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 cs-high write ignored", fifo_empty, 1);
        // R8 writes in receive mode ignored
        bit_div = 8'd255;
        mode = 2'd2;
        wr_byte(8'h01); wr_byte(8'h02); wr_byte(8'h03);
        mode = 2'd0;
        cs_release();
        chk("R8 rx-mode write ignored", fifo_empty, 1);

        // R9 bit enable period and standby silence
        bit_div = 8'd3;
        mode = 2'd1;
        @(negedge clk);
        wait_tick();
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (bit_en !== 1'b1);
        chk("R9 period", cyc, 4);
        mode = 2'd0;
        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            if (bit_en !== 1'b0) bad++;
            @(negedge clk);
        end
        chk("R9 standby silent", bad, 0);

        // R10/R11 transmit MSB first and end of packet
        txb[0] = 8'hB4; txb[1] = 8'h5C;
        do_flush();
        wr_byte(txb[0]); wr_byte(txb[1]);
        cs_n = 1'b1;
        bit_div = 8'd2;
        mode = 2'd1;
        @(negedge clk);
        bad = 0;
        for (int k = 0; k < 16; k++) begin
            wait_tick();
            @(negedge clk);
            if (tx_data !== txb[k / 8][7 - (k % 8)]) bad++;
            if (pkt_sent !== 1'b0) bad++;
        end
        chk("R10 serial bits", bad, 0);
        wait_tick();
        @(negedge clk);
        chk("R11 sent after last bit", pkt_sent, 1);
        chk("R11 tx idle", tx_data, 0);
        repeat (3) @(negedge clk);
        chk("R3 empty after tx", fifo_empty, 1);
        mode = 2'd0;
        repeat (2) @(negedge clk);
        chk("R11 sent clears on mode change", pkt_sent, 0);

        // R12 receive assembly
        rxb[0] = 8'h96; rxb[1] = 8'h3B;
        do_flush();
        cs_n = 1'b1;
        bit_div = 8'd1;
        mode = 2'd2;
        @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            wait_tick();
            rx_in = rxb[k / 8][7 - (k % 8)];
            @(negedge clk);
        end
        mode = 2'd0;
        rx_in = 1'b0;
        @(negedge clk);
        rd_byte(b);
        chk("R12 first byte", b, rxb[0]);
        rd_byte(b);
        chk("R12 second byte", b, rxb[1]);
        cs_release();
        chk("R12 empty after reads", fifo_empty, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule